// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block performs the state update a processor core makes at the moment it takes an exception. The core raises a one-cycle request carrying an exception type, the PC of the faulting instruction, whether that instruction sits in a branch delay slot (and whether the branch was a half-size one), the current EXL, ERL and BEV status bits, the exception base register, and the interrupt-vectoring inputs (the IV enable bit, the vector spacing field and the pending and mask bit vectors). On that clock edge the block writes the resume PC into the proper return register, records the cause code, updates the branch-delay and status bits, and presents the handler address on `new_pc_o`. A one-cycle `done_o` pulse follows.

Ordinary exceptions, which carry a cause code, vector from a base chosen by BEV and a per-type offset. The error-level entries (non-maskable interrupt and soft reset) and the debug entry use fixed addresses and their own return registers. A type outside the supported set changes no state and produces a one-cycle `err_o` pulse instead of `done_o`.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset every register output (`epc_o`, `errepc_o`, `depc_o`, `new_pc_o`, `code_o`, `bd_o`, `exl_o`, `erl_o`, `bev_o`, `sr_o`, `nmi_o`, `done_o`, `err_o`) reads zero.
- R2: Type values 0 to 31 select an ordinary exception whose cause code is the type value itself; only codes 0-13, 15, 19, 20, 24 and 30 are supported. On a supported ordinary request `code_o` takes that 5-bit code and, in the cycle after the request, `done_o` is 1 for exactly one cycle.
- R3: An ordinary exception's handler address is base + offset, where base is 0xBFC00200 when `bev_i` is 1 and `ebase_i` with bits 9:0 cleared otherwise; the offset is 0x180 unless R4, R5 or R6 applies.
- R4: Type 2 (TLB load) or 3 (TLB store) with `refill_i` = 1 and `exl_i` = 0 uses offset 0x000; with `exl_i` = 1 it uses 0x180.
- R5: Type 0 (interrupt) with `iv_i` = 1 uses offset 0x200 when `bev_i` = 1 or `spacing_i` = 0, and otherwise 0x200 + v × (`spacing_i` × 32), where v is the index of the highest set bit of `pend_i & mask_i` (0 when none is set). With `iv_i` = 0 the offset is 0x180.
- R6: Type 30 (cache error) uses offset 0x100 when `bev_i` = 1 and 0x20000100 otherwise.
- R7: For an ordinary exception, `epc_o` and `bd_o` are written only when `exl_i` = 0; `bd_o` takes `in_slot_i`. `exl_o` becomes 1; `erl_o` and `bev_o` take `erl_i` and `bev_i`.
- R8: The resume PC is `pc_i`, minus 4 when `in_slot_i` = 1, or minus 2 when `in_slot_i` = 1 and `half_br_i` = 1.
- R9: Type 32 (NMI) and type 33 (soft reset) write the resume PC into `errepc_o`, set `erl_o` and `bev_o`, pass `exl_i` to `exl_o`, clear `bd_o` when `exl_i` = 0, and set `new_pc_o` to 0xBFC00000. Type 33 sets the sticky `sr_o`; type 32 sets the sticky `nmi_o`. `code_o` and `epc_o` are left unchanged.
- R10: Type 34 (debug) writes the resume PC into `depc_o`, sets `new_pc_o` to 0xBFC00480, passes the three status inputs through, clears `bd_o` when `exl_i` = 0, and leaves `code_o`, `epc_o` and `errepc_o` unchanged.
- R11: Any other type (unsupported code below 32, or 35 to 63) changes no output register, gives no `done_o`, and pulses `err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle exception request |
| type_i | input | 6 | Exception type (0-31 cause code, 32 NMI, 33 soft reset, 34 debug) |
| pc_i | input | 32 | PC of the excepting instruction |
| in_slot_i | input | 1 | Instruction is in a branch delay slot |
| half_br_i | input | 1 | The branch owning the delay slot is half size |
| refill_i | input | 1 | TLB exception is a miss (no matching entry) |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-exception-vector bit |
| ebase_i | input | 32 | Exception base register |
| iv_i | input | 1 | Dedicated interrupt vector enable |
| spacing_i | input | 5 | Interrupt vector spacing field |
| pend_i | input | 8 | Pending interrupt lines |
| mask_i | input | 8 | Interrupt mask bits |
| epc_o | output | 32 | Exception return PC |
| errepc_o | output | 32 | Error-level return PC |
| depc_o | output | 32 | Debug return PC |
| new_pc_o | output | 32 | Handler address |
| code_o | output | 5 | Recorded cause code |
| bd_o | output | 1 | Branch-delay indication |
| exl_o | output | 1 | New exception-level bit |
| erl_o | output | 1 | New error-level bit |
| bev_o | output | 1 | New boot-vector bit |
| sr_o | output | 1 | Sticky soft-reset flag |
| nmi_o | output | 1 | Sticky NMI flag |
| done_o | output | 1 | Entry completed (one cycle after request) |
| err_o | output | 1 | Unsupported type rejected (one cycle after request) |

## Verification
The hardest corner to reach is the vectored interrupt whose offset depends on a wide product of the priority index and the spacing, with BEV clear, IV set and a nonzero spacing all at once, and the highest enabled line at the top of the vector. Random stimulus draws pending and mask independently and makes spacing zero only part of the time, while directed requests force the top line with maximum spacing. A second hard case is the held-EPC path: EXL set together with a delay-slot instruction and a refill miss, so the refill offset must fall back to 0x180 and the stale EPC must survive; the random mix sets EXL on about half the requests to cover it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int TYPE_W = 6;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    CLS_GEN = 2'd0,
    CLS_ERR = 2'd1,
    CLS_DBG = 2'd2,
    CLS_BAD = 2'd3
  } exc_class_e;

  localparam logic [TYPE_W-1:0] TY_IRQ   = 6'd0;
  localparam logic [TYPE_W-1:0] TY_TLBL  = 6'd2;
  localparam logic [TYPE_W-1:0] TY_TLBS  = 6'd3;
  localparam logic [TYPE_W-1:0] TY_CACHE = 6'd30;
  localparam logic [TYPE_W-1:0] TY_NMI   = 6'd32;
  localparam logic [TYPE_W-1:0] TY_SRST  = 6'd33;
  localparam logic [TYPE_W-1:0] TY_DBG   = 6'd34;

  localparam logic [31:0] BOOT_GEN_BASE = 32'hBFC0_0200;
  localparam logic [31:0] ERR_ENTRY_PC  = 32'hBFC0_0000;
  localparam logic [31:0] DBG_ENTRY_PC  = 32'hBFC0_0480;
endpackage

// File: rtl/exc_type_decode.sv
module exc_type_decode
  import exc_pkg::*;
(
  input  logic [TYPE_W-1:0] type_i,
  output exc_class_e        cls_o,
  output logic [CODE_W-1:0] code_o,
  output logic              is_irq_o,
  output logic              is_tlb_o,
  output logic              is_cache_o,
  output logic              is_nmi_o,
  output logic              is_srst_o
);
  function automatic logic code_supported(input logic [CODE_W-1:0] c);
    logic [31:0] okmap;
    okmap = 32'h0000_3FFF | (32'd1 << 15) | (32'd1 << 19) | (32'd1 << 20)
          | (32'd1 << 24) | (32'd1 << 30);
    return okmap[c];
  endfunction

  always_comb begin
    code_o     = type_i[CODE_W-1:0];
    is_irq_o   = (type_i == TY_IRQ);
    is_tlb_o   = (type_i == TY_TLBL) || (type_i == TY_TLBS);
    is_cache_o = (type_i == TY_CACHE);
    is_nmi_o   = (type_i == TY_NMI);
    is_srst_o  = (type_i == TY_SRST);
    if (type_i[TYPE_W-1] == 1'b0)
      cls_o = code_supported(type_i[CODE_W-1:0]) ? CLS_GEN : CLS_BAD;
    else if (is_nmi_o || is_srst_o)
      cls_o = CLS_ERR;
    else if (type_i == TY_DBG)
      cls_o = CLS_DBG;
    else
      cls_o = CLS_BAD;
  end
endmodule

// File: rtl/exc_resume_calc.sv
module exc_resume_calc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_slot_i,
  input  logic            half_br_i,
  output logic [XLEN-1:0] resume_o
);
  function automatic logic [XLEN-1:0] back_step(input logic slot, input logic half);
    if (!slot) return '0;
    return half ? XLEN'(2) : XLEN'(4);
  endfunction

  assign resume_o = pc_i - back_step(in_slot_i, half_br_i);
endmodule

// File: rtl/exc_offset_gen.sv
module exc_offset_gen #(
  parameter int XLEN      = 32,
  parameter int IRQ_N     = 8,
  parameter int SPACING_W = 5
) (
  input  logic                 is_irq_i,
  input  logic                 is_tlb_i,
  input  logic                 is_cache_i,
  input  logic                 refill_i,
  input  logic                 exl_i,
  input  logic                 bev_i,
  input  logic [XLEN-1:0]      ebase_i,
  input  logic                 iv_i,
  input  logic [SPACING_W-1:0] spacing_i,
  input  logic [IRQ_N-1:0]     pend_i,
  input  logic [IRQ_N-1:0]     mask_i,
  output logic [XLEN-1:0]      offset_o,
  output logic [XLEN-1:0]      target_o
);
  localparam int IDX_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;
  localparam logic [XLEN-1:0] BASE_ALIGN = XLEN'(32'h3FF);

  function automatic logic [IDX_W-1:0] top_index(input logic [IRQ_N-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < IRQ_N; i++)
      if (v[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  function automatic logic [XLEN-1:0] irq_offset(input logic [IDX_W-1:0] vec,
                                                 input logic [SPACING_W-1:0] sp);
    return XLEN'(32'h200) + XLEN'(vec) * (XLEN'(sp) << 5);
  endfunction

  logic [IDX_W-1:0] irq_vec;
  logic [XLEN-1:0]  base;

  assign irq_vec = top_index(pend_i & mask_i);
  assign base    = bev_i ? XLEN'(exc_pkg::BOOT_GEN_BASE) : (ebase_i & ~BASE_ALIGN);

  always_comb begin
    offset_o = XLEN'(32'h180);
    if (is_cache_i)
      offset_o = bev_i ? XLEN'(32'h100) : XLEN'(32'h2000_0100);
    else if (is_tlb_i && refill_i && !exl_i)
      offset_o = '0;
    else if (is_irq_i && iv_i)
      offset_o = (bev_i || spacing_i == '0) ? XLEN'(32'h200) : irq_offset(irq_vec, spacing_i);
  end

  assign target_o = base + offset_o;
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IRQ_N     = 8,
  parameter int SPACING_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [TYPE_W-1:0]    type_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic                 in_slot_i,
  input  logic                 half_br_i,
  input  logic                 refill_i,
  input  logic                 exl_i,
  input  logic                 erl_i,
  input  logic                 bev_i,
  input  logic [XLEN-1:0]      ebase_i,
  input  logic                 iv_i,
  input  logic [SPACING_W-1:0] spacing_i,
  input  logic [IRQ_N-1:0]     pend_i,
  input  logic [IRQ_N-1:0]     mask_i,
  output logic [XLEN-1:0]      epc_o,
  output logic [XLEN-1:0]      errepc_o,
  output logic [XLEN-1:0]      depc_o,
  output logic [XLEN-1:0]      new_pc_o,
  output logic [CODE_W-1:0]    code_o,
  output logic                 bd_o,
  output logic                 exl_o,
  output logic                 erl_o,
  output logic                 bev_o,
  output logic                 sr_o,
  output logic                 nmi_o,
  output logic                 done_o,
  output logic                 err_o
);
  exc_class_e        cls;
  logic [CODE_W-1:0] dec_code;
  logic              is_irq, is_tlb, is_cache, is_nmi, is_srst;
  logic [XLEN-1:0]   resume_pc;
  logic [XLEN-1:0]   vec_offset;
  logic [XLEN-1:0]   gen_target;

  // named events for the checker
  logic take_gen, take_err, take_dbg, reject;
  logic save_epc;

  exc_type_decode u_decode (
    .type_i    (type_i),
    .cls_o     (cls),
    .code_o    (dec_code),
    .is_irq_o  (is_irq),
    .is_tlb_o  (is_tlb),
    .is_cache_o(is_cache),
    .is_nmi_o  (is_nmi),
    .is_srst_o (is_srst)
  );

  exc_resume_calc #(.XLEN(XLEN)) u_resume (
    .pc_i     (pc_i),
    .in_slot_i(in_slot_i),
    .half_br_i(half_br_i),
    .resume_o (resume_pc)
  );

  exc_offset_gen #(.XLEN(XLEN), .IRQ_N(IRQ_N), .SPACING_W(SPACING_W)) u_offset (
    .is_irq_i  (is_irq),
    .is_tlb_i  (is_tlb),
    .is_cache_i(is_cache),
    .refill_i  (refill_i),
    .exl_i     (exl_i),
    .bev_i     (bev_i),
    .ebase_i   (ebase_i),
    .iv_i      (iv_i),
    .spacing_i (spacing_i),
    .pend_i    (pend_i),
    .mask_i    (mask_i),
    .offset_o  (vec_offset),
    .target_o  (gen_target)
  );

  assign take_gen = req_i && (cls == CLS_GEN);
  assign take_err = req_i && (cls == CLS_ERR);
  assign take_dbg = req_i && (cls == CLS_DBG);
  assign reject   = req_i && (cls == CLS_BAD);
  assign save_epc = take_gen && !exl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o    <= '0;
      errepc_o <= '0;
      depc_o   <= '0;
      new_pc_o <= '0;
      code_o   <= '0;
      bd_o     <= 1'b0;
      exl_o    <= 1'b0;
      erl_o    <= 1'b0;
      bev_o    <= 1'b0;
      sr_o     <= 1'b0;
      nmi_o    <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= take_gen || take_err || take_dbg;
      err_o  <= reject;
      if (take_gen) begin
        if (save_epc) begin
          epc_o <= resume_pc;
          bd_o  <= in_slot_i;
        end
        exl_o    <= 1'b1;
        erl_o    <= erl_i;
        bev_o    <= bev_i;
        code_o   <= dec_code;
        new_pc_o <= gen_target;
      end
      if (take_err) begin
        errepc_o <= resume_pc;
        if (!exl_i) bd_o <= 1'b0;
        exl_o    <= exl_i;
        erl_o    <= 1'b1;
        bev_o    <= 1'b1;
        new_pc_o <= XLEN'(ERR_ENTRY_PC);
        if (is_srst) sr_o  <= 1'b1;
        if (is_nmi)  nmi_o <= 1'b1;
      end
      if (take_dbg) begin
        depc_o   <= resume_pc;
        if (!exl_i) bd_o <= 1'b0;
        exl_o    <= exl_i;
        erl_o    <= erl_i;
        bev_o    <= bev_i;
        new_pc_o <= XLEN'(DBG_ENTRY_PC);
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_i,
  input logic            exl_i,
  input logic            take_gen,
  input logic            take_err,
  input logic            take_dbg,
  input logic            reject,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic [4:0]      code_o,
  input logic            bd_o,
  input logic            exl_o,
  input logic            erl_o,
  input logic            bev_o,
  input logic            done_o,
  input logic            err_o
);
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen || take_err || take_dbg) |=> (done_o && !err_o));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!done_o && !err_o));

  a_r7_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    take_gen |=> exl_o);

  a_r7_epc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen && exl_i) |=> ($stable(epc_o) && $stable(bd_o)));

  a_r9_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take_err |=> (erl_o && bev_o && new_pc_o == XLEN'(32'hBFC0_0000)));

  a_r10_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (new_pc_o == XLEN'(32'hBFC0_0480) && $stable(code_o) && $stable(epc_o)));

  a_r11_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_o && !done_o && $stable(epc_o) && $stable(new_pc_o)
                && $stable(code_o) && $stable(exl_o)));
endmodule

bind exc_entry_unit exc_entry_checker #(.XLEN(XLEN)) u_exc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .exl_i   (exl_i),
  .take_gen(take_gen),
  .take_err(take_err),
  .take_dbg(take_dbg),
  .reject  (reject),
  .epc_o   (epc_o),
  .new_pc_o(new_pc_o),
  .code_o  (code_o),
  .bd_o    (bd_o),
  .exl_o   (exl_o),
  .erl_o   (erl_o),
  .bev_o   (bev_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [5:0]  type_i = '0;
  logic [31:0] pc_i = '0;
  logic        in_slot_i = 1'b0, half_br_i = 1'b0, refill_i = 1'b0;
  logic        exl_i = 1'b0, erl_i = 1'b0, bev_i = 1'b0, iv_i = 1'b0;
  logic [31:0] ebase_i = '0;
  logic [4:0]  spacing_i = '0;
  logic [7:0]  pend_i = '0, mask_i = '0;
  logic [31:0] epc_o, errepc_o, depc_o, new_pc_o;
  logic [4:0]  code_o;
  logic        bd_o, exl_o, erl_o, bev_o, sr_o, nmi_o, done_o, err_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench-side expected state
  logic [31:0] m_epc = 0, m_errepc = 0, m_depc = 0, m_pc = 0;
  logic [4:0]  m_code = 0;
  logic        m_bd = 0, m_exl = 0, m_erl = 0, m_bev = 0, m_sr = 0, m_nmi = 0;
  logic        m_done = 0, m_err = 0;

  always #5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .type_i(type_i), .pc_i(pc_i),
    .in_slot_i(in_slot_i), .half_br_i(half_br_i), .refill_i(refill_i),
    .exl_i(exl_i), .erl_i(erl_i), .bev_i(bev_i), .ebase_i(ebase_i), .iv_i(iv_i),
    .spacing_i(spacing_i), .pend_i(pend_i), .mask_i(mask_i),
    .epc_o(epc_o), .errepc_o(errepc_o), .depc_o(depc_o), .new_pc_o(new_pc_o),
    .code_o(code_o), .bd_o(bd_o), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
    .sr_o(sr_o), .nmi_o(nmi_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_ordinary(input logic [5:0] t);
    if (t > 6'd31) return 0;
    return (t <= 6'd13) || t == 6'd15 || t == 6'd19 || t == 6'd20 ||
           t == 6'd24 || t == 6'd30;
  endfunction

  function automatic logic [31:0] resume_of(input logic [31:0] pc, input logic s, input logic h);
    if (s && h) return pc - 32'd2;
    if (s) return pc - 32'd4;
    return pc;
  endfunction

  function automatic logic [31:0] handler_of(input logic [5:0] t);
    logic [31:0] b, off;
    int v;
    b = bev_i ? 32'hBFC0_0200 : {ebase_i[31:10], 10'd0};
    off = 32'h180;
    if (t == 6'd30) off = bev_i ? 32'h100 : 32'h2000_0100;
    else if ((t == 6'd2 || t == 6'd3) && refill_i && !exl_i) off = 0;
    else if (t == 6'd0 && iv_i) begin
      if (bev_i || spacing_i == 0) off = 32'h200;
      else begin
        v = 0;
        for (int k = 7; k >= 0; k--)
          if (v == 0 && (pend_i[k] & mask_i[k])) v = k;
        off = 32'h200 + v * spacing_i * 32;
      end
    end
    return b + off;
  endfunction

  function automatic string tag_of(input logic [5:0] t);
    if (t == 6'd32 || t == 6'd33) return "R9";
    if (t == 6'd34) return "R10";
    if (!is_ordinary(t)) return "R11";
    if (t == 6'd30) return "R6";
    if (t == 6'd0) return "R5";
    if (t == 6'd2 || t == 6'd3) return "R4";
    return "R3";
  endfunction

  task automatic model(input logic [5:0] t);
    m_done = 0; m_err = 0;
    if (is_ordinary(t)) begin
      if (!exl_i) begin
        m_epc = resume_of(pc_i, in_slot_i, half_br_i);
        m_bd = in_slot_i;
      end
      m_exl = 1; m_erl = erl_i; m_bev = bev_i;
      m_code = t[4:0]; m_pc = handler_of(t); m_done = 1;
    end else if (t == 6'd32 || t == 6'd33) begin
      m_errepc = resume_of(pc_i, in_slot_i, half_br_i);
      if (!exl_i) m_bd = 0;
      m_exl = exl_i; m_erl = 1; m_bev = 1; m_pc = 32'hBFC0_0000;
      if (t == 6'd33) m_sr = 1; else m_nmi = 1;
      m_done = 1;
    end else if (t == 6'd34) begin
      m_depc = resume_of(pc_i, in_slot_i, half_br_i);
      if (!exl_i) m_bd = 0;
      m_exl = exl_i; m_erl = erl_i; m_bev = bev_i; m_pc = 32'hBFC0_0480;
      m_done = 1;
    end else begin
      m_err = 1;
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "new_pc", new_pc_o, m_pc);
    check((tag == "R11") ? "R11" : "R7", "epc", epc_o, m_epc);
    check((tag == "R11") ? "R11" : "R2", "code", {27'd0, code_o}, {27'd0, m_code});
    check((tag == "R11") ? "R11" : "R7", "bd", {31'd0, bd_o}, {31'd0, m_bd});
    check((tag == "R11") ? "R11" : "R7", "exl", {31'd0, exl_o}, {31'd0, m_exl});
    check(tag, "erl", {31'd0, erl_o}, {31'd0, m_erl});
    check(tag, "bev", {31'd0, bev_o}, {31'd0, m_bev});
    check((tag == "R11") ? "R11" : "R8", "errepc", errepc_o, m_errepc);
    check((tag == "R11") ? "R11" : "R8", "depc", depc_o, m_depc);
    check(tag, "sr", {31'd0, sr_o}, {31'd0, m_sr});
    check(tag, "nmi", {31'd0, nmi_o}, {31'd0, m_nmi});
    check((tag == "R11") ? "R11" : "R2", "done", {31'd0, done_o}, {31'd0, m_done});
    check("R11", "err", {31'd0, err_o}, {31'd0, m_err});
  endtask

  // request applied at negedge, result sampled at the following negedge
  task automatic fire(input logic [5:0] t);
    type_i = t;
    req_i = 1'b1;
    model(t);
    @(negedge clk);
    req_i = 1'b0;
    compare_all(tag_of(t));
    @(negedge clk);
    check("R2", "done_drop", {31'd0, done_o}, 32'd0);
    check("R11", "err_drop", {31'd0, err_o}, 32'd0);
  endtask

  task automatic set_ctx(input logic [31:0] pc, input logic s, input logic h, input logic rf,
                         input logic x, input logic e, input logic b, input logic [31:0] eb,
                         input logic iv, input logic [4:0] sp, input logic [7:0] p,
                         input logic [7:0] m);
    pc_i = pc; in_slot_i = s; half_br_i = h; refill_i = rf; exl_i = x; erl_i = e;
    bev_i = b; ebase_i = eb; iv_i = iv; spacing_i = sp; pend_i = p; mask_i = m;
  endtask

  logic [5:0] pick_list [0:22] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7,
    6'd8, 6'd9, 6'd10, 6'd11, 6'd12, 6'd13, 6'd15, 6'd19, 6'd20, 6'd24, 6'd30,
    6'd32, 6'd33, 6'd34, 6'd14};

  initial begin
    #3000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "epc", epc_o, 0);
    check("R1", "new_pc", new_pc_o, 0);
    check("R1", "flags", {19'd0, code_o, bd_o, exl_o, erl_o, bev_o, sr_o, nmi_o, done_o, err_o}, 0);
    check("R1", "retregs", errepc_o | depc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: vectored interrupt, highest enabled line 7, spacing 1
    set_ctx(32'h8000_0100, 0, 0, 0, 0, 0, 0, 32'h8000_1234, 1, 5'd1, 8'h90, 8'hF0);
    fire(6'd0);
    // R5: max spacing, line 7
    set_ctx(32'h8000_0200, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 5'd31, 8'hFF, 8'h80);
    fire(6'd0);
    // R5: spacing zero and BEV set
    set_ctx(32'h8000_0300, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 5'd0, 8'h04, 8'h04);
    fire(6'd0);
    set_ctx(32'h8000_0300, 0, 0, 0, 0, 0, 1, 32'h8000_0000, 1, 5'd4, 8'h04, 8'h04);
    fire(6'd0);
    // R4: refill miss with EXL clear then set, delay slot (R8)
    set_ctx(32'h0040_1000, 1, 0, 1, 0, 0, 0, 32'h8000_0000, 0, 0, 0, 0);
    fire(6'd2);
    set_ctx(32'h0040_2000, 1, 1, 1, 1, 0, 0, 32'h8000_0000, 0, 0, 0, 0);
    fire(6'd3);
    // R6: cache error both BEV values
    set_ctx(32'h0000_0010, 0, 0, 0, 0, 0, 0, 32'h8000_4000, 0, 0, 0, 0);
    fire(6'd30);
    set_ctx(32'h0000_0010, 0, 0, 0, 0, 0, 1, 32'h8000_4000, 0, 0, 0, 0);
    fire(6'd30);
    // R8 half-size branch, R9, R10, R11
    set_ctx(32'h1000_0008, 1, 1, 0, 0, 0, 0, 32'h8000_0000, 0, 0, 0, 0);
    fire(6'd32);
    fire(6'd33);
    fire(6'd34);
    fire(6'd14);
    fire(6'd40);

    for (int n = 0; n < 600; n++) begin
      logic [5:0] t;
      t = ($urandom % 10 == 0) ? 6'($urandom) : pick_list[$urandom % 23];
      set_ctx({$urandom, 2'b00} >> 0, 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), ($urandom % 4 == 0), $urandom,
              ($urandom % 4 != 0), ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
              8'($urandom), 8'($urandom));
      fire(t);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule